// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a bank of digital input lines, makes their settled levels readable over a small 32-bit register bus, and watches the lowest lines for change-of-state events that raise one interrupt output. Software loads two per-channel masks, one for rising edges or high levels and one for falling edges or low levels. It then picks how the selected channels combine. In edge-OR mode, any qualifying edge on a selected channel is enough. In level-AND mode, every selected channel must sit at its chosen level at the same time.

In level-AND mode a match latches the engine, so a condition that simply stays true does not refire. The engine re-arms only after a level change on one of the selected inputs. When an event fires, the status register takes a snapshot of the watched lines and holds it until software reads it. That read clears both the snapshot and the pending interrupt. The enable bit gates the interrupt output, and clearing it leaves the masks and the mode as they were.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, every register (offsets 0x04, 0x08, 0x0C, 0x10) reads zero and `irq` is low.
- R2: A read at offset 0x00 returns all N_IN input lines, zero-extended, after two synchronising clock stages.
- R3: The masks at 0x04 (rise/high) and 0x08 (fall/low) keep only their low N_COS bits, and their other bits read zero. The control register at 0x10 keeps only bit 1 (mode: 0 = edge-OR, 1 = level-AND) and bit 2 (enable); all its other bits read zero.
- R4: With enable set and edge-OR mode selected, a rising edge on a channel set in the rise mask, or a falling edge on a channel set in the fall mask, sets `irq` on the third clock edge after the input changes.
- R5: In edge-OR mode, a rising edge on a channel clear in the rise mask, or a falling edge on a channel clear in the fall mask, does not raise `irq`.
- R6: In level-AND mode with at least one channel selected, `irq` is raised exactly when every channel in the rise mask is high and every channel in the fall mask is low.
- R7: After a level-AND event the engine stays latched while the match persists. It fires again only after a level change on a selected channel followed by a renewed match.
- R8: When an event fires, the status register at 0x0C captures the levels of lines 0 to N_COS-1 at that moment. A status read returns that value, then clears the register to zero and drops `irq`.
- R9: Writing control with bit 2 clear lowers `irq` on the next cycle and leaves both masks unchanged. Edges seen while disabled raise nothing. Restoring the enable shows a pending event again.
- R10: While both masks are zero, `irq` is never raised, in either mode.
- R11: Lines at index N_COS and above never cause an interrupt, whatever the masks hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lines | input | N_IN (32) | Asynchronous digital input lines |
| bus_addr | input | ADDR_W (5) | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; a status read clears status at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request, gated by the enable bit |

## Verification
The bench builds the block with N_IN = 8 and N_COS = 4, which keeps each mask at 16 values. Edge-OR mode is swept over every pair of rise and fall masks, with a rising and a falling edge on each watched channel. Level-AND mode is swept over every pair of masks against every input pattern, and the latch and re-arm sequence is run for each matching case. The four unwatched lines are toggled under every mask pair, so the boundary at N_COS can be observed directly at the ports.

// File: rtl/cos_pkg.sv
package cos_pkg;

   // Byte offsets on the register bus
   localparam int unsigned OFF_RAW  = 32'h00;
   localparam int unsigned OFF_RISE = 32'h04;
   localparam int unsigned OFF_FALL = 32'h08;
   localparam int unsigned OFF_STAT = 32'h0C;
   localparam int unsigned OFF_CTRL = 32'h10;

   // Control field positions
   localparam int unsigned CTRL_MODE_BIT = 1;
   localparam int unsigned CTRL_EN_BIT   = 2;

   typedef enum logic {
      MODE_OR  = 1'b0,
      MODE_AND = 1'b1
   } comb_mode_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0][N-1:0] stage_q;
   logic [N-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   // previous settled sample, used for edge pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[LAST];
   end

   assign level_o = stage_q[LAST];

   for (genvar b = 0; b < N; b++) begin : g_edge
      assign rise_o[b] =  stage_q[LAST][b] & ~prev_q[b];
      assign fall_o[b] = ~stage_q[LAST][b] &  prev_q[b];
   end

endmodule

// File: rtl/cos_regs.sv
module cos_regs
   import cos_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int N_IN   = 32,
   parameter int N_COS  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_IN-1:0]   level_i,
   input  logic [N_COS-1:0]  status_i,
   output logic [N_COS-1:0]  hi_o,
   output logic [N_COS-1:0]  lo_o,
   output comb_mode_e        mode_o,
   output logic              en_o,
   output logic              stat_clr_o
);

   logic [N_COS-1:0] hi_q, lo_q;
   logic             mode_q, en_q;
   logic             sel_raw, sel_rise, sel_fall, sel_stat, sel_ctrl;
   logic             unused_wdata;

   assign sel_raw  = (addr == ADDR_W'(OFF_RAW));
   assign sel_rise = (addr == ADDR_W'(OFF_RISE));
   assign sel_fall = (addr == ADDR_W'(OFF_FALL));
   assign sel_stat = (addr == ADDR_W'(OFF_STAT));
   assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         mode_q <= 1'b0;
         en_q   <= 1'b0;
      end else if (wr_en) begin
         if (sel_rise) hi_q <= wdata[N_COS-1:0];
         if (sel_fall) lo_q <= wdata[N_COS-1:0];
         if (sel_ctrl) begin
            mode_q <= wdata[CTRL_MODE_BIT];
            en_q   <= wdata[CTRL_EN_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_raw)  rdata[N_IN-1:0]  = level_i;
      if (sel_rise) rdata[N_COS-1:0] = hi_q;
      if (sel_fall) rdata[N_COS-1:0] = lo_q;
      if (sel_stat) rdata[N_COS-1:0] = status_i;
      if (sel_ctrl) begin
         rdata[CTRL_MODE_BIT] = mode_q;
         rdata[CTRL_EN_BIT]   = en_q;
      end
   end

   assign hi_o       = hi_q;
   assign lo_o       = lo_q;
   assign mode_o     = comb_mode_e'(mode_q);
   assign en_o       = en_q;
   assign stat_clr_o = rd_en && sel_stat;

   // R9
   masks_kept_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_ctrl) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/cos_engine.sv
module cos_engine
   import cos_pkg::*;
#(
   parameter int N_COS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_COS-1:0] level_i,
   input  logic [N_COS-1:0] rise_i,
   input  logic [N_COS-1:0] fall_i,
   input  logic [N_COS-1:0] hi_i,
   input  logic [N_COS-1:0] lo_i,
   input  comb_mode_e       mode_i,
   input  logic             en_i,
   input  logic             clr_i,
   output logic [N_COS-1:0] status_o,
   output logic             irq_o
);

   logic [N_COS-1:0] sel, status_q;
   logic             or_hit, and_match, chg, lat_q, lat_eff, fire, pend_q;

   assign sel       = hi_i | lo_i;
   assign or_hit    = |((rise_i & hi_i) | (fall_i & lo_i));
   assign and_match = (|sel) && ((level_i & hi_i) == hi_i)
                             && ((~level_i & lo_i) == lo_i);
   assign chg       = |((rise_i | fall_i) & sel);

   // a change on a selected line releases the latch in the same cycle
   assign lat_eff = lat_q & ~chg;

   always_comb begin
      fire = 1'b0;
      if (en_i) begin
         if (mode_i == MODE_OR) fire = or_hit;
         else                   fire = and_match & ~lat_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 1'b0;
      end else if (!en_i || mode_i != MODE_AND) begin
         lat_q <= 1'b0;
      end else if (fire) begin
         lat_q <= 1'b1;
      end else if (chg) begin
         lat_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         status_q <= '0;
      end else begin
         if (fire)       pend_q <= 1'b1;
         else if (clr_i) pend_q <= 1'b0;
         if (fire && (!pend_q || clr_i)) status_q <= level_i;
         else if (clr_i)                 status_q <= '0;
      end
   end

   assign status_o = status_q;
   assign irq_o    = pend_q & en_i;

   // R10
   zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_i == '0 && lo_i == '0 && !pend_q) |=> !pend_q);

   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !fire) |=> (status_q == '0 && !pend_q));

   // R7
   and_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && mode_i == MODE_AND && lat_q && !chg && !pend_q) |=> !pend_q);

   // R4
   or_edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && mode_i == MODE_OR && or_hit) |=> pend_q);

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
   import cos_pkg::*;
#(
   parameter int N_IN        = 32,
   parameter int N_COS       = 16,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   in_lines,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   if (N_COS < 1 || N_COS > N_IN) begin : g_bad_cos
      $error("cos_irq_ctrl: N_COS must lie in 1..N_IN");
   end
   if (N_IN > DATA_W || DATA_W < 3) begin : g_bad_data
      $error("cos_irq_ctrl: DATA_W must hold N_IN lines and the control bits");
   end
   if (ADDR_W < 5 || SYNC_STAGES < 1) begin : g_bad_addr
      $error("cos_irq_ctrl: ADDR_W must reach offset 0x10 and SYNC_STAGES be >= 1");
   end

   logic [N_IN-1:0]  level, rise, fall;
   logic [N_COS-1:0] hi_m, lo_m, status;
   comb_mode_e       mode;
   logic             en, stat_clr;
   logic             unused_edges;

   assign unused_edges = ^{rise, fall};

   cos_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (in_lines),
      .level_o (level),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   cos_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IN(N_IN), .N_COS(N_COS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wr_en      (bus_wr),
      .rd_en      (bus_rd),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .level_i    (level),
      .status_i   (status),
      .hi_o       (hi_m),
      .lo_o       (lo_m),
      .mode_o     (mode),
      .en_o       (en),
      .stat_clr_o (stat_clr)
   );

   cos_engine #(.N_COS(N_COS)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (level[N_COS-1:0]),
      .rise_i   (rise[N_COS-1:0]),
      .fall_i   (fall[N_COS-1:0]),
      .hi_i     (hi_m),
      .lo_i     (lo_m),
      .mode_i   (mode),
      .en_i     (en),
      .clr_i    (stat_clr),
      .status_o (status),
      .irq_o    (irq)
   );

   // R9
   disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[CTRL_EN_BIT]) |=> !irq);

endmodule

// File: tb/cos_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cos_irq_ctrl_bench;

   localparam int NI = 8;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] lines = '0;
   logic [4:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int  n_total = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   cos_irq_ctrl #(.N_IN(NI), .N_COS(NC), .ADDR_W(5), .DATA_W(32), .SYNC_STAGES(2))
   u_cos_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .in_lines(lines), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 0);
      rd(5'h04, d); check("R1 rise mask", d, 0);
      rd(5'h08, d); check("R1 fall mask", d, 0);
      rd(5'h0C, d); check("R1 status", d, 0);
      rd(5'h10, d); check("R1 ctrl", d, 0);

      // R2 raw lines
      lines = 8'hA5; idle(3);
      rd(5'h00, d); check("R2 raw A5", d, 32'hA5);
      lines = 8'h3C; idle(3);
      rd(5'h00, d); check("R2 raw 3C", d, 32'h3C);
      lines = 8'h00; idle(4);

      // R3 field widths
      wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); check("R3 rise width", d, 32'hF);
      wr(5'h08, 32'hFFFF_FFF5); rd(5'h08, d); check("R3 fall width", d, 32'h5);
      wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R3 ctrl bits", d, 32'h6);
      wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
      rd(5'h0C, d);

      // R4 R5 R8 R10 R11: edge-OR sweep
      for (int h = 0; h < 16; h++) begin
         for (int l = 0; l < 16; l++) begin
            wr(5'h10, 0);
            rd(5'h0C, d);
            lines = '0;
            wr(5'h04, h); wr(5'h08, l);
            wr(5'h10, 32'h4);
            idle(2);
            for (int c = 0; c < NC; c++) begin
               lines[c] = 1'b1; idle(4);
               check((h[c] ? "R4 rise" : ((h | l) == 0 ? "R10 rise" : "R5 rise")),
                     {31'b0, irq}, {31'b0, h[c]});
               rd(5'h0C, d);
               check("R8 status after rise", d, h[c] ? (32'h1 << c) : 0);
               check("R8 irq after read", {31'b0, irq}, 0);
               lines[c] = 1'b0; idle(4);
               check((l[c] ? "R4 fall" : ((h | l) == 0 ? "R10 fall" : "R5 fall")),
                     {31'b0, irq}, {31'b0, l[c]});
               rd(5'h0C, d);
               check("R8 status after fall", d, 0);
               check("R8 irq after read", {31'b0, irq}, 0);
            end
            lines = 8'hF0; idle(4);
            check("R11 upper rise", {31'b0, irq}, 0);
            lines = 8'h00; idle(4);
            check("R11 upper fall", {31'b0, irq}, 0);
         end
      end

      // R6 R7 R8 R10: level-AND sweep
      for (int h = 0; h < 16; h++) begin
         for (int l = 0; l < 16; l++) begin
            for (int p = 0; p < 16; p++) begin
               logic exp_m;
               int   b;
               exp_m = ((h | l) != 0) && ((p & h) == h) && ((~p & l) == l);
               wr(5'h10, 0);
               rd(5'h0C, d);
               lines = NI'(p);
               wr(5'h04, h); wr(5'h08, l);
               wr(5'h10, 32'h6);
               idle(2);
               check(((h | l) == 0) ? "R10 and" : "R6 and match",
                     {31'b0, irq}, {31'b0, exp_m});
               if (exp_m) begin
                  rd(5'h0C, d);
                  check("R8 and status", d, p);
                  idle(3);
                  check("R7 latched", {31'b0, irq}, 0);
                  b = 0;
                  while (((h | l) >> b & 1) == 0) b++;
                  lines = NI'(p ^ (1 << b)); idle(4);
                  check("R7 released mismatch", {31'b0, irq}, 0);
                  lines = NI'(p); idle(4);
                  check("R7 rearmed", {31'b0, irq}, 1);
               end
            end
         end
      end

      // R9 enable gating
      wr(5'h10, 0); rd(5'h0C, d);
      lines = '0;
      wr(5'h04, 32'h1); wr(5'h08, 32'h0); wr(5'h10, 32'h4);
      idle(2);
      lines[0] = 1'b1; idle(4);
      check("R9 raised", {31'b0, irq}, 1);
      wr(5'h10, 0);
      check("R9 disable lowers irq", {31'b0, irq}, 0);
      rd(5'h04, d); check("R9 rise mask kept", d, 1);
      rd(5'h08, d); check("R9 fall mask kept", d, 0);
      wr(5'h10, 32'h4);
      check("R9 pending shows again", {31'b0, irq}, 1);
      rd(5'h0C, d); check("R9 status", d, 1);
      check("R9 cleared", {31'b0, irq}, 0);
      wr(5'h10, 0);
      lines[0] = 1'b0; idle(4);
      lines[0] = 1'b1; idle(4);
      wr(5'h10, 32'h4); idle(3);
      check("R9 edges while disabled ignored", {31'b0, irq}, 0);
      rd(5'h0C, d); check("R9 status untouched", d, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule